// File: doc/BRIEF.md
# Interrupt and Stack Entry Sequencer

This block runs the multi-cycle control sequences an 8-bit processor with a 16-bit address bus needs when it enters or leaves an exception context. It handles four events: reset, a non-maskable interrupt, a maskable interrupt request and the software break instruction. For every entry except reset it saves the return address and a status byte on a hardware stack held in a fixed memory page. It then raises the interrupt-disable flag and fetches the new program counter from the vector pair that belongs to the event. It also performs the opposite sequence, return-from-interrupt, which restores the status and the program counter from the stack.

The surrounding core gives the block its current program counter and status byte. It pulses a request line when it decodes a break or a return instruction. While `seq_busy` is high the core lets the block own the memory port. When the block asserts its load strobes, the core takes the new program counter and status values from the block's outputs. The memory port is a plain synchronous one: read data appears one clock after the address. The block holds the stack pointer and exposes it as a 9-bit value whose top bit is always 1.

Top module: `vec_entry_seq`

## Requirements
- R1: When `rst_n` is released, the block is busy for exactly 4 cycles and performs no memory write. In the first cycle it sets the stack pointer to 0x1FF. It then loads the program counter from the reset pair, low byte at 0xFFFC and high byte at 0xFFFD, and it loads status with bit 2 (interrupt disable) set.
- R2: The non-maskable interrupt takes its vector from 0xFFFA (low byte) and 0xFFFB (high byte). The maskable request and the break instruction share 0xFFFE (low byte) and 0xFFFF (high byte). The low byte is read before the high byte.
- R3: Every stack access uses the address 0x0100 + (low 8 bits of the stack pointer). A push writes to the current location and then decrements the pointer by 1. A pull first increments the pointer and then reads.
- R4: An entry sequence writes three bytes to the stack in this order: return address bits 15:8, return address bits 7:0, status.
- R5: A break request stacks `pc_in` + 2 and stacks the status with bits 4 and 5 set. From the first busy cycle to the cycle with `pc_load` it takes 7 cycles.
- R6: An interrupt entry (maskable or non-maskable) stacks `pc_in` unchanged and stacks the status with bit 4 clear and bit 5 set. It takes 7 cycles.
- R7: During every entry, `p_load` presents `p_in` with bit 2 set and bit 4 cleared. All other bits are unchanged.
- R8: The maskable request `irq_n` is level-sensitive and active low. It is accepted only while the block is idle and `p_in` bit 2 is 0.
- R9: A falling edge on `nmi_n` is latched even while the block is busy, and it causes exactly one entry. Holding `nmi_n` low does not cause a second entry. The priority when idle is: non-maskable interrupt, then maskable request, then break, then return.
- R10: Return-from-interrupt takes 6 cycles and performs three pulls: status, then return address bits 7:0, then bits 15:8. The pulled status is presented on `p_load` with bit 4 cleared and bit 5 set.
- R11: `sp_wr` replaces the low 8 bits of the stack pointer with `sp_wdata` only while the block is idle and is not accepting a request. At any other time it is ignored.
- R12: `seq_done` is a one-cycle pulse in the last busy cycle and coincides with `pc_load`. `brk_req` and `rti_req` have no effect while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the reset sequence |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge triggered |
| irq_n | input | 1 | Maskable interrupt request, active-low level |
| brk_req | input | 1 | Break instruction decoded |
| rti_req | input | 1 | Return-from-interrupt instruction decoded |
| pc_in | input | 16 | Current program counter of the core |
| p_in | input | 8 | Current status byte of the core |
| sp_wr | input | 1 | Stack pointer write strobe from the core |
| sp_wdata | input | 8 | New low byte of the stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| pc_load | output | 1 | Core must load `pc_out` |
| pc_out | output | 16 | New program counter |
| p_load | output | 1 | Core must load `p_out` |
| p_out | output | 8 | New status byte |
| sp_out | output | 9 | Stack pointer, bit 8 always 1 |
| seq_busy | output | 1 | A sequence owns the memory port |
| seq_done | output | 1 | Final cycle of a sequence |

## Verification
The bench targets the break-flag asymmetry. A design that put bit 4 into the live status, or that stacked it for hardware interrupts, would show a wrong `p_out` value or a wrong third stacked byte. An edge on `nmi_n` that arrives in the same cycle as a maskable request, or in the middle of a break sequence, must still win or stay pending. A level-triggered or unlatched implementation would either re-enter while `nmi_n` is held low or lose the event. The return sequence is checked against the bytes a preceding break left on the stack. An off-by-one in the increment-then-read order would restore a return address shifted by one byte. Stack-pointer writes and instruction requests issued mid-sequence are checked for leaving the pointer and the port untouched.

// File: rtl/ves_pkg.sv
package ves_pkg;

   // status bit positions the sequencer touches
   localparam int FLAG_I = 2;
   localparam int FLAG_B = 4;
   localparam int FLAG_U = 5;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RST,
      ST_SETUP,
      ST_PUSH_H,
      ST_PUSH_L,
      ST_PUSH_P,
      ST_VEC_L,
      ST_VEC_H,
      ST_R_DUMMY,
      ST_R_INC,
      ST_R_P,
      ST_R_L,
      ST_R_H,
      ST_LOAD
   } seq_state_e;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_RST,
      SRC_NMI,
      SRC_IRQ,
      SRC_BRK,
      SRC_RTI
   } seq_src_e;

   typedef enum logic [2:0] {
      SP_HOLD,
      SP_INIT,
      SP_DEC,
      SP_INC,
      SP_LOAD
   } sp_op_e;

endpackage

// File: rtl/ves_req_arb.sv
module ves_req_arb
   import ves_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     nmi_n,
   input  logic     irq_n,
   input  logic     brk_req,
   input  logic     rti_req,
   input  logic     i_flag,
   input  logic     idle,
   input  logic     accept,
   output seq_src_e req_src,
   output logic     req_valid,
   output logic     nmi_pending
);

   logic nmi_s;
   logic irq_s;
   logic nmi_prev_q;
   logic nmi_pend_q;
   logic nmi_edge;
   logic nmi_hot;

   // optional input synchronisers, chosen by parameter
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign nmi_s = nmi_n;
         assign irq_s = irq_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] nmi_sh_q;
         logic [SYNC_STAGES-1:0] irq_sh_q;
         for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  nmi_sh_q[k] <= 1'b1;
                  irq_sh_q[k] <= 1'b1;
               end else if (k == 0) begin
                  nmi_sh_q[k] <= nmi_n;
                  irq_sh_q[k] <= irq_n;
               end else begin
                  nmi_sh_q[k] <= nmi_sh_q[(k == 0) ? 0 : k-1];
                  irq_sh_q[k] <= irq_sh_q[(k == 0) ? 0 : k-1];
               end
            end
         end
         assign nmi_s = nmi_sh_q[SYNC_STAGES-1];
         assign irq_s = irq_sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign nmi_edge = nmi_prev_q & ~nmi_s;
   assign nmi_hot  = nmi_pend_q | nmi_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev_q <= 1'b1;
         nmi_pend_q <= 1'b0;
      end else begin
         nmi_prev_q <= nmi_s;
         if (accept && req_src == SRC_NMI)
            nmi_pend_q <= 1'b0;
         else if (nmi_edge)
            nmi_pend_q <= 1'b1;
      end
   end

   // fixed priority among the requesters
   always_comb begin
      if (nmi_hot)
         req_src = SRC_NMI;
      else if (!irq_s && !i_flag)
         req_src = SRC_IRQ;
      else if (brk_req)
         req_src = SRC_BRK;
      else if (rti_req)
         req_src = SRC_RTI;
      else
         req_src = SRC_NONE;
   end

   assign req_valid   = idle && (req_src != SRC_NONE);
   assign nmi_pending = nmi_pend_q;

   // R8: a masked request never starts a sequence
   a_r8_irq_masked : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_src == SRC_IRQ) |-> !i_flag);

   // R9: a pending edge beats every other source
   a_r9_nmi_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && nmi_pend_q) |-> (req_src == SRC_NMI));

   // R9: a latched edge is only dropped when it is taken
   a_r9_pend_kept : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nmi_pend_q) |-> $past(accept));

endmodule

// File: rtl/ves_stack_unit.sv
module ves_stack_unit
   import ves_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  sp_op_e                op,
   input  logic [DATA_W-1:0]     load_val,
   output logic [2*DATA_W-1:0]   stack_addr,
   output logic [DATA_W:0]       sp_full
);

   localparam logic [DATA_W-1:0] SP_TOP = '1;

   logic [DATA_W-1:0] sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= SP_TOP;
      end else begin
         unique case (op)
            SP_INIT: sp_q <= SP_TOP;
            SP_DEC:  sp_q <= sp_q - 1'b1;
            SP_INC:  sp_q <= sp_q + 1'b1;
            SP_LOAD: sp_q <= load_val;
            default: sp_q <= sp_q;
         endcase
      end
   end

   assign stack_addr = {STACK_PAGE, sp_q};
   assign sp_full    = {1'b1, sp_q};

   // R1: initialisation lands on the top of the page
   a_r1_sp_init : assert property (@(posedge clk) disable iff (!rst_n)
      (op == SP_INIT) |=> (sp_q == SP_TOP));

endmodule

// File: rtl/ves_seq_fsm.sv
module ves_seq_fsm
   import ves_pkg::*;
#(
   parameter int                ADDR_W        = 16,
   parameter int                DATA_W        = 8,
   parameter logic [DATA_W-1:0] STACK_PAGE    = 8'h01,
   parameter logic [ADDR_W-1:0] VEC_NMI       = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_RST       = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_IRQ       = 16'hFFFE,
   parameter int                BRK_PC_OFFSET = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_src_e          req_src,
   input  logic              req_valid,
   output logic              accept,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] p_in,
   input  logic              sp_wr,
   input  logic [ADDR_W-1:0] stack_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_out,
   output logic              p_load,
   output logic [DATA_W-1:0] p_out,
   output logic              busy,
   output logic              done,
   output sp_op_e            sp_op
);

   localparam logic [ADDR_W-1:0] BRK_ADD = ADDR_W'(BRK_PC_OFFSET);
   localparam logic [DATA_W-1:0] MASK_I  = DATA_W'(1) << FLAG_I;
   localparam logic [DATA_W-1:0] MASK_B  = DATA_W'(1) << FLAG_B;
   localparam logic [DATA_W-1:0] MASK_U  = DATA_W'(1) << FLAG_U;

   seq_state_e        state_q, state_d;
   seq_src_e          src_q;
   logic [ADDR_W-1:0] ret_q;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] lo_q;
   logic [ADDR_W-1:0] vec_base;

   assign accept = req_valid && (state_q == ST_IDLE);
   assign busy   = (state_q != ST_IDLE);

   // vector pair for the event being served
   always_comb begin
      unique case (src_q)
         SRC_NMI: vec_base = VEC_NMI;
         SRC_RST: vec_base = VEC_RST;
         default: vec_base = VEC_IRQ;
      endcase
   end

   // state sequencing
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (accept)
                        state_d = (req_src == SRC_RTI) ? ST_R_DUMMY : ST_SETUP;
         ST_RST:     state_d = ST_VEC_L;
         ST_SETUP:   state_d = ST_PUSH_H;
         ST_PUSH_H:  state_d = ST_PUSH_L;
         ST_PUSH_L:  state_d = ST_PUSH_P;
         ST_PUSH_P:  state_d = ST_VEC_L;
         ST_VEC_L:   state_d = ST_VEC_H;
         ST_VEC_H:   state_d = ST_LOAD;
         ST_R_DUMMY: state_d = ST_R_INC;
         ST_R_INC:   state_d = ST_R_P;
         ST_R_P:     state_d = ST_R_L;
         ST_R_L:     state_d = ST_R_H;
         ST_R_H:     state_d = ST_LOAD;
         ST_LOAD:    state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RST;
         src_q   <= SRC_RST;
         ret_q   <= '0;
         stat_q  <= '0;
         lo_q    <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            src_q  <= req_src;
            stat_q <= p_in;
            ret_q  <= (req_src == SRC_BRK) ? pc_in + BRK_ADD : pc_in;
         end
         if (state_q == ST_VEC_H || state_q == ST_R_H)
            lo_q <= mem_rdata;
      end
   end

   // per-state outputs
   always_comb begin
      mem_addr  = stack_addr;
      mem_we    = 1'b0;
      mem_wdata = '0;
      pc_load   = 1'b0;
      pc_out    = {mem_rdata, lo_q};
      p_load    = 1'b0;
      p_out     = p_in;
      done      = 1'b0;
      sp_op     = SP_HOLD;
      unique case (state_q)
         ST_IDLE: begin
            if (sp_wr && !accept)
               sp_op = SP_LOAD;
         end
         ST_RST: begin
            sp_op = SP_INIT;
         end
         ST_PUSH_H: begin
            mem_we    = 1'b1;
            mem_wdata = ret_q[ADDR_W-1:DATA_W];
            sp_op     = SP_DEC;
         end
         ST_PUSH_L: begin
            mem_we    = 1'b1;
            mem_wdata = ret_q[DATA_W-1:0];
            sp_op     = SP_DEC;
         end
         ST_PUSH_P: begin
            mem_we    = 1'b1;
            mem_wdata = (stat_q & ~MASK_B) | MASK_U
                        | ((src_q == SRC_BRK) ? MASK_B : '0);
            sp_op     = SP_DEC;
         end
         ST_VEC_L: begin
            mem_addr = vec_base;
            p_load   = 1'b1;
            p_out    = (p_in | MASK_I) & ~MASK_B;
         end
         ST_VEC_H: begin
            mem_addr = vec_base + 1'b1;
         end
         ST_R_INC, ST_R_P: begin
            sp_op = SP_INC;
         end
         ST_R_L: begin
            sp_op  = SP_INC;
            p_load = 1'b1;
            p_out  = (mem_rdata & ~MASK_B) | MASK_U;
         end
         ST_LOAD: begin
            pc_load = 1'b1;
            done    = 1'b1;
         end
         default: ;
      endcase
   end

   // R3: writes only ever land in the stack page
   a_r3_we_in_page : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE));

   // R12: completion is a single-cycle pulse
   a_r12_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12: no new sequence starts in the cycle right after one ends
   a_r12_no_reenter : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !pc_load);

endmodule

// File: rtl/vec_entry_seq.sv
module vec_entry_seq
   import ves_pkg::*;
#(
   parameter int          ADDR_W        = 16,
   parameter int          DATA_W        = 8,
   parameter logic [7:0]  STACK_PAGE    = 8'h01,
   parameter logic [15:0] VEC_NMI       = 16'hFFFA,
   parameter logic [15:0] VEC_RST       = 16'hFFFC,
   parameter logic [15:0] VEC_IRQ       = 16'hFFFE,
   parameter int          BRK_PC_OFFSET = 2,
   parameter int          SYNC_STAGES   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_n,
   input  logic              irq_n,
   input  logic              brk_req,
   input  logic              rti_req,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] p_in,
   input  logic              sp_wr,
   input  logic [DATA_W-1:0] sp_wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_out,
   output logic              p_load,
   output logic [DATA_W-1:0] p_out,
   output logic [DATA_W:0]   sp_out,
   output logic              seq_busy,
   output logic              seq_done
);

   // elaboration-time parameter checks
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("address width must be twice the data width");
      end
      if (DATA_W <= FLAG_U) begin : g_bad_data
         $error("data width too small for the status bits");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("synchroniser depth must lie in 0..3");
      end
      if (BRK_PC_OFFSET < 0 || BRK_PC_OFFSET > 3) begin : g_bad_off
         $error("break return offset must lie in 0..3");
      end
   endgenerate

   seq_src_e          req_src;
   logic              req_valid;
   logic              accept;
   logic              nmi_pending;
   sp_op_e            sp_op;
   logic [ADDR_W-1:0] stack_addr;

   ves_req_arb #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .nmi_n       (nmi_n),
      .irq_n       (irq_n),
      .brk_req     (brk_req),
      .rti_req     (rti_req),
      .i_flag      (p_in[FLAG_I]),
      .idle        (!seq_busy),
      .accept      (accept),
      .req_src     (req_src),
      .req_valid   (req_valid),
      .nmi_pending (nmi_pending)
   );

   ves_stack_unit #(
      .DATA_W     (DATA_W),
      .STACK_PAGE (DATA_W'(STACK_PAGE))
   ) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (sp_op),
      .load_val   (sp_wdata),
      .stack_addr (stack_addr),
      .sp_full    (sp_out)
   );

   ves_seq_fsm #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .STACK_PAGE    (DATA_W'(STACK_PAGE)),
      .VEC_NMI       (ADDR_W'(VEC_NMI)),
      .VEC_RST       (ADDR_W'(VEC_RST)),
      .VEC_IRQ       (ADDR_W'(VEC_IRQ)),
      .BRK_PC_OFFSET (BRK_PC_OFFSET)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_src    (req_src),
      .req_valid  (req_valid),
      .accept     (accept),
      .pc_in      (pc_in),
      .p_in       (p_in),
      .sp_wr      (sp_wr),
      .stack_addr (stack_addr),
      .mem_rdata  (mem_rdata),
      .mem_addr   (mem_addr),
      .mem_we     (mem_we),
      .mem_wdata  (mem_wdata),
      .pc_load    (pc_load),
      .pc_out     (pc_out),
      .p_load     (p_load),
      .p_out      (p_out),
      .busy       (seq_busy),
      .done       (seq_done),
      .sp_op      (sp_op)
   );

   // R3: each stack write is followed by a decrement of the pointer
   a_r3_push_then_dec : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (sp_out[DATA_W-1:0] == $past(sp_out[DATA_W-1:0]) - 1'b1));

   // R12: the port is only written during a sequence
   a_r12_we_busy : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> seq_busy);

   // R11: the pointer never moves while idle without a write strobe
   a_r11_sp_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_busy && !sp_wr && !$past(seq_busy)) |=> $stable(sp_out) || seq_busy);

endmodule

// File: tb/test_vec_entry_seq.sv
module test_vec_entry_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_n = 1'b1;
   logic        irq_n = 1'b1;
   logic        brk_req = 1'b0;
   logic        rti_req = 1'b0;
   logic [15:0] pc_in = 16'h0000;
   logic [7:0]  p_in = 8'h00;
   logic        sp_wr = 1'b0;
   logic [7:0]  sp_wdata = 8'h00;
   logic [15:0] mem_addr;
   logic        mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic        pc_load;
   logic [15:0] pc_out;
   logic        p_load;
   logic [7:0]  p_out;
   logic [8:0]  sp_out;
   logic        seq_busy;
   logic        seq_done;

   always #2 clk = ~clk;

   vec_entry_seq i_vec_entry_seq (
      .clk (clk), .rst_n (rst_n), .nmi_n (nmi_n), .irq_n (irq_n),
      .brk_req (brk_req), .rti_req (rti_req), .pc_in (pc_in), .p_in (p_in),
      .sp_wr (sp_wr), .sp_wdata (sp_wdata), .mem_addr (mem_addr),
      .mem_we (mem_we), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
      .pc_load (pc_load), .pc_out (pc_out), .p_load (p_load), .p_out (p_out),
      .sp_out (sp_out), .seq_busy (seq_busy), .seq_done (seq_done)
   );

   // memory model: stack page and vector bytes, one-cycle read latency
   logic [7:0] stk [256];
   logic [7:0] vec [6];

   function automatic logic [7:0] rd(input logic [15:0] a);
      if (a[15:8] == 8'h01) return stk[a[7:0]];
      if (a >= 16'hFFFA)    return vec[3'(a - 16'hFFFA)];
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= rd(mem_addr);
   end

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   int          n_we, n_pl, n_pcl, n_done;
   logic [15:0] w_addr [4];
   logic [7:0]  w_data [4];
   logic [15:0] got_pc;
   logic [7:0]  got_p;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // follow one busy stretch, sampling at falling edges
   task automatic observe(output int cyc);
      cyc = 0; n_we = 0; n_pl = 0; n_pcl = 0; n_done = 0;
      while (seq_busy && cyc < 40) begin
         if (mem_we) begin
            if (n_we < 4) begin
               w_addr[n_we] = mem_addr;
               w_data[n_we] = mem_wdata;
            end
            n_we++;
         end
         if (p_load)  begin got_p = p_out; n_pl++; end
         if (pc_load) begin got_pc = pc_out; n_pcl++; end
         if (seq_done) n_done++;
         if (seq_done && !pc_load) n_done += 100;
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic chk_push(input string tag, input logic [7:0] sp0,
                           input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
      chk({tag, " write count"}, n_we, 3);
      chk({tag, " addr0"}, w_addr[0], {8'h01, sp0});
      chk({tag, " addr1"}, w_addr[1], {8'h01, sp0 - 8'd1});
      chk({tag, " addr2"}, w_addr[2], {8'h01, sp0 - 8'd2});
      chk({tag, " byte0"}, w_data[0], b0);
      chk({tag, " byte1"}, w_data[1], b1);
      chk({tag, " byte2"}, w_data[2], b2);
   endtask

   task automatic t_reset();
      int cyc;
      repeat (3) @(negedge clk);
      chk("R1 no write in reset", mem_we, 0);
      chk("R1 sp in reset", sp_out, 9'h1FF);
      rst_n = 1'b1;
      observe(cyc);
      chk("R1 reset cycles", cyc, 4);
      chk("R1 reset writes", n_we, 0);
      chk("R1 R2 reset vector", got_pc, 16'hB022);
      chk("R1 reset I flag", got_p, 8'h04);
      chk("R1 sp after reset", sp_out, 9'h1FF);
      chk("R12 reset done pulse", n_done, 1);
   endtask

   task automatic t_brk();
      int cyc;
      pc_in = 16'h1234; p_in = 8'h81;
      brk_req = 1'b1;
      @(negedge clk);
      brk_req = 1'b0;
      observe(cyc);
      chk("R5 brk cycles", cyc, 7);
      chk_push("R3 R4 R5 brk", 8'hFF, 8'h12, 8'h36, 8'hB1);
      chk("R3 brk sp", sp_out, 9'h1FC);
      chk("R2 brk vector", got_pc, 16'hC033);
      chk("R7 brk status", got_p, 8'h85);
      chk("R12 brk done", n_done, 1);
   endtask

   task automatic t_rti();
      int cyc;
      p_in = 8'h04;
      rti_req = 1'b1;
      @(negedge clk);
      rti_req = 1'b0;
      observe(cyc);
      chk("R10 rti cycles", cyc, 6);
      chk("R10 rti writes", n_we, 0);
      chk("R10 rti pc", got_pc, 16'h1236);
      chk("R10 rti status", got_p, 8'hA1);
      chk("R10 R3 rti sp", sp_out, 9'h1FF);
   endtask

   task automatic t_irq();
      int cyc;
      int seen = 0;
      p_in = 8'h04; pc_in = 16'h4000;
      irq_n = 1'b0;
      repeat (6) begin
         @(negedge clk);
         if (seq_busy) seen++;
      end
      chk("R8 masked irq ignored", seen, 0);
      p_in = 8'h02;
      @(negedge clk);
      irq_n = 1'b1;
      observe(cyc);
      chk("R6 irq cycles", cyc, 7);
      chk_push("R4 R6 irq", 8'hFF, 8'h40, 8'h00, 8'h22);
      chk("R2 irq vector", got_pc, 16'hC033);
      chk("R7 irq status", got_p, 8'h06);
   endtask

   task automatic t_nmi_prio();
      int cyc;
      int seen = 0;
      p_in = 8'h40; pc_in = 16'h5678;
      nmi_n = 1'b0; irq_n = 1'b0;
      @(negedge clk);
      irq_n = 1'b1;
      observe(cyc);
      chk("R9 nmi over irq vector", got_pc, 16'hA011);
      chk("R6 nmi cycles", cyc, 7);
      chk_push("R6 nmi", 8'hFC, 8'h56, 8'h78, 8'h60);
      chk("R7 nmi status", got_p, 8'h44);
      repeat (5) begin
         @(negedge clk);
         if (seq_busy) seen++;
      end
      chk("R9 held low no retrigger", seen, 0);
      nmi_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_nmi_during_brk();
      int cyc;
      sp_wr = 1'b1; sp_wdata = 8'hFF;
      @(negedge clk);
      sp_wr = 1'b0;
      @(negedge clk);
      chk("R11 sp write idle", sp_out, 9'h1FF);
      pc_in = 16'h0100; p_in = 8'h00;
      brk_req = 1'b1;
      @(negedge clk);
      brk_req = 1'b0;
      fork
         observe(cyc);
         begin
            repeat (2) @(negedge clk);
            nmi_n = 1'b0; sp_wr = 1'b1; sp_wdata = 8'h10;
            @(negedge clk);
            nmi_n = 1'b1; sp_wr = 1'b0;
         end
      join
      chk("R5 brk with nmi cycles", cyc, 7);
      chk_push("R5 brk under nmi", 8'hFF, 8'h01, 8'h02, 8'h30);
      chk("R11 sp write ignored busy", sp_out, 9'h1FC);
      pc_in = 16'h9ABC;
      @(negedge clk);
      chk("R9 latched nmi starts", seq_busy, 1);
      fork
         observe(cyc);
         begin
            repeat (2) @(negedge clk);
            brk_req = 1'b1;
            @(negedge clk);
            brk_req = 1'b0;
         end
      join
      chk("R9 latched nmi vector", got_pc, 16'hA011);
      chk_push("R6 latched nmi", 8'hFC, 8'h9A, 8'hBC, 8'h20);
      begin
         int seen = 0;
         repeat (4) begin
            @(negedge clk);
            if (seq_busy) seen++;
         end
         chk("R12 brk while busy ignored", seen, 0);
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) stk[i] = 8'h00;
      vec[0] = 8'h11; vec[1] = 8'hA0;
      vec[2] = 8'h22; vec[3] = 8'hB0;
      vec[4] = 8'h33; vec[5] = 8'hC0;
      @(negedge clk);
      t_reset();
      t_brk();
      t_rti();
      t_irq();
      t_nmi_prio();
      t_nmi_during_brk();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule